// File: doc/BRIEF.md
# Priority Interrupt Controller with Nesting

This block gathers interrupt requests from up to eight sources, such as program faults, an internal timer, I/O controllers and hardware-failure lines. It presents a simple processor core with one interrupt line and a binary source vector. The core checks the line once per instruction cycle. When it takes the interrupt, it acknowledges in the same cycle, reads the vector and jumps to the matching handler. When the handler ends, the core pulses an end-of-handler strobe.

A mode input picks one of two service policies. In sequential mode only one handler runs at a time. Requests that arrive meanwhile are held, and they are served later strictly in the order they came in. In nested mode, sources have a fixed priority where index 0 ranks highest. A request that outranks every handler now in service interrupts the running handler. The end-of-handler strobe retires only the innermost (highest-priority) handler, so service falls back to the handler it preempted.

The controller keeps a pending flag and an in-service flag for each source. Sequential ordering comes from a small queue of source indices.

Top module: `pic_nest_top`

## Requirements
- R1: After synchronous reset, `irq_o` is low, `vec_o` is 0, and nothing is pending or in service.
- R2: A source becomes pending on a rising edge of its request line, and `irq_o` can rise on the clock edge that registers that rise. A line held high raises only one request.
- R3: An acknowledge while `irq_o` is high clears the pending flag of the source named on `vec_o` and marks that source in service. An acknowledge while `irq_o` is low has no effect.
- R4: In sequential mode (`nest_mode_i` = 0), `irq_o` stays low while any source is in service. Requests that arrive meanwhile stay pending.
- R5: In sequential mode, sources are presented in the order their requests arrived. Sources that arrive in the same cycle are ordered lowest index first.
- R6: In nested mode (`nest_mode_i` = 1), `vec_o` is the lowest-indexed pending source. `irq_o` is high only when that index is strictly lower than every in-service index.
- R7: In nested mode, a preempted handler stays in service while a higher one runs. A lower-priority pending request is presented only after every handler that outranks it has ended.
- R8: The end-of-handler strobe clears only the lowest-indexed in-service flag. With nothing in service, the strobe has no effect.
- R9: A new rising edge from a source that is already pending is merged into that request, so the source is served once.

`vec_o` carries the source index in binary. The mode input may change only while nothing is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 8 | Request lines, one per source; bit 0 has the highest priority |
| nest_mode_i | input | 1 | 0 = sequential service, 1 = nested priority service |
| ack_i | input | 1 | Processor takes the interrupt named on vec_o |
| eoi_i | input | 1 | End-of-handler strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 3 | Binary index of the source being presented |

## Verification
The assertions check several rules on every cycle. The arrival queue never overflows and is never popped while empty. Sequential mode never has more than one source in service. In nested mode, a raised interrupt always outranks every in-service source. An accepted acknowledge always marks its source in service, and an end-of-handler strobe retires exactly one flag. Some behaviour depends on the history of many cycles, and only the bench scenarios can show it: arrival order across separate and simultaneous requests, merging of repeated edges, a held level giving a single request, and preempted handlers resuming in the right order.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic {
        MODE_SEQ  = 1'b0,
        MODE_NEST = 1'b1
    } mode_e;

    localparam int MAX_SRC = 32;
    localparam int MAX_IDX_W = 5;

    typedef struct packed {
        logic                 hit;
        logic [MAX_IDX_W-1:0] idx;
    } first_t;

    // lowest set bit of a vector (highest priority)
    function automatic first_t find_first(input logic [MAX_SRC-1:0] v);
        first_t r;
        r = '0;
        for (int i = MAX_SRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = MAX_IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] new_o
);
    logic [N-1:0] req_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;
    logic [N-1:0] kept;

    assign rise   = req_i & ~req_q;
    assign kept   = pend_q & ~clr_i;
    assign new_o  = rise & ~kept;
    assign pend_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req_i;
            pend_q <= kept | rise;
        end
    end

    // R2: a rising edge always leaves its source pending
    a_r2_rise_sets_pending: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

endmodule

// File: rtl/pic_order_fifo.sv
module pic_order_fifo #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     push_i,
    input  logic             pop_i,
    output logic             empty_o,
    output logic [IDX_W-1:0] head_o
);
    logic [IDX_W-1:0] mem_q [N];
    logic [IDX_W-1:0] mem_n [N];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] wr;

    always_comb begin
        mem_n = mem_q;
        cnt_n = cnt_q;
        if (pop_i && cnt_q != '0) begin
            for (int j = 0; j < N - 1; j++) begin
                mem_n[j] = mem_q[j + 1];
            end
            cnt_n = cnt_q - 1'b1;
        end
        // same-cycle arrivals go in lowest index first
        wr = cnt_n;
        for (int i = 0; i < N; i++) begin
            if (push_i[i] && wr < CNT_W'(N)) begin
                mem_n[wr[IDX_W-1:0]] = IDX_W'(i);
                wr = wr + 1'b1;
            end
        end
        cnt_n = wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int k = 0; k < N; k++) begin
                mem_q[k] <= '0;
            end
        end else begin
            cnt_q <= cnt_n;
            mem_q <= mem_n;
        end
    end

    assign empty_o = (cnt_q == '0);
    assign head_o  = mem_q[0];

    // R5: queue never exceeds one entry per source
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_q) - int'(pop_i) + $countones(push_i)) <= N);

    // R5: nothing is taken from an empty queue
    a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (cnt_q != '0));

endmodule

// File: rtl/pic_service.sv
module pic_service
    import pic_pkg::*;
#(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode_i,
    input  logic [N-1:0]     pend_i,
    input  logic             fifo_empty_i,
    input  logic [IDX_W-1:0] fifo_head_i,
    input  logic             ack_i,
    input  logic             eoi_i,
    output logic             irq_o,
    output logic [IDX_W-1:0] vec_o,
    output logic             take_o,
    output logic [N-1:0]     take_mask_o
);
    logic [N-1:0] isr_q;
    logic [N-1:0] isr_n;
    logic [N-1:0] eoi_mask;
    first_t       hp;
    first_t       hs;

    always_comb begin
        hp = find_first(MAX_SRC'(pend_i));
        hs = find_first(MAX_SRC'(isr_q));
        if (mode_i == MODE_NEST) begin
            irq_o = hp.hit && (!hs.hit || hp.idx < hs.idx);
            vec_o = hp.idx[IDX_W-1:0];
        end else begin
            irq_o = !fifo_empty_i && (isr_q == '0);
            vec_o = fifo_head_i;
        end
        take_o      = ack_i && irq_o;
        take_mask_o = take_o ? (N'(1) << vec_o) : '0;
        eoi_mask    = (eoi_i && hs.hit) ? (N'(1) << hs.idx[IDX_W-1:0]) : '0;
        isr_n       = (isr_q & ~eoi_mask) | take_mask_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
        end else begin
            isr_q <= isr_n;
        end
    end

    // R3: an accepted acknowledge marks its source in service
    a_r3_take_sets_isr: assert property (@(posedge clk) disable iff (rst)
        take_o |=> isr_q[$past(vec_o)]);

    // R4: sequential mode runs one handler at a time
    a_r4_seq_single: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_SEQ) |-> $onehot0(isr_q));

    // R6: in nested mode a raised request outranks all in-service sources
    a_r6_nest_outranks: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_NEST && irq_o) |->
        ((isr_q & ((N'(2) << vec_o) - N'(1))) == '0));

    // R8: end-of-handler retires exactly one in-service flag
    a_r8_eoi_one: assert property (@(posedge clk) disable iff (rst)
        (eoi_i && !take_o && isr_q != '0) |=>
        ($countones(isr_q) == $countones($past(isr_q)) - 1));

endmodule

// File: rtl/pic_nest_top.sv
module pic_nest_top
    import pic_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req_i,
    input  logic                 nest_mode_i,
    input  logic                 ack_i,
    input  logic                 eoi_i,
    output logic                 irq_o,
    output logic [$clog2(N)-1:0] vec_o
);
    localparam int IDX_W = $clog2(N);

    mode_e            mode;
    logic [N-1:0]     pend;
    logic [N-1:0]     arrivals;
    logic [N-1:0]     push;
    logic [N-1:0]     take_mask;
    logic             take;
    logic             pop;
    logic             fifo_empty;
    logic [IDX_W-1:0] fifo_head;

    assign mode = mode_e'(nest_mode_i);
    assign push = (mode == MODE_SEQ) ? arrivals : '0;
    assign pop  = take && (mode == MODE_SEQ);

    pic_req_capture #(.N(N)) u_capture (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .clr_i  (take_mask),
        .pend_o (pend),
        .new_o  (arrivals)
    );

    pic_order_fifo #(.N(N)) u_order (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .pop_i   (pop),
        .empty_o (fifo_empty),
        .head_o  (fifo_head)
    );

    pic_service #(.N(N)) u_service (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode),
        .pend_i       (pend),
        .fifo_empty_i (fifo_empty),
        .fifo_head_i  (fifo_head),
        .ack_i        (ack_i),
        .eoi_i        (eoi_i),
        .irq_o        (irq_o),
        .vec_o        (vec_o),
        .take_o       (take),
        .take_mask_o  (take_mask)
    );

    // R1: nothing pending means no interrupt
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq_o);

    // R3: the presented source is always pending
    a_r3_vec_pending: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pend[vec_o]);

endmodule

// File: tb/pic_nest_top_tb.sv
module pic_nest_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req = '0;
    logic       nest = 1'b0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq;
    logic [2:0] vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    pic_nest_top #(.N(8)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .nest_mode_i (nest),
        .ack_i       (ack),
        .eoi_i       (eoi),
        .irq_o       (irq),
        .vec_o       (vec)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_irq(input string tag, input logic exp);
        check(irq == exp, tag, int'(irq), int'(exp));
    endtask

    task automatic pulse(input logic [7:0] m);
        req = m;
        tick();
        req = '0;
        tick();
    endtask

    task automatic take(input string tag, input int exp_vec);
        check(irq == 1'b1, {tag, " irq"}, int'(irq), 1);
        check(int'(vec) == exp_vec, {tag, " vec"}, int'(vec), exp_vec);
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic end_handler();
        eoi = 1'b1;
        tick();
        eoi = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
        tick();
        check_irq("R1 reset irq", 1'b0);
        check(vec == 3'd0, "R1 reset vec", int'(vec), 0);
    endtask

    task automatic t_edge_level();
        nest = 1'b0;
        req = 8'b0000_1000;
        tick();
        check_irq("R2 irq after rise", 1'b1);
        check(vec == 3'd3, "R2 vec after rise", int'(vec), 3);
        take("R2 take", 3);
        end_handler();
        tick();
        check_irq("R2 held level no rerequest", 1'b0);
        req = '0;
        tick();
    endtask

    task automatic t_ack_ignored();
        nest = 1'b0;
        ack = 1'b1;
        tick();
        ack = 1'b0;
        pulse(8'b0010_0000);
        take("R3 take after stray ack", 5);
        check_irq("R3 irq drops after ack", 1'b0);
        end_handler();
        end_handler();
        pulse(8'b0100_0000);
        take("R8 extra eoi harmless", 6);
        end_handler();
        check_irq("R8 idle after eoi", 1'b0);
    endtask

    task automatic t_seq_order();
        nest = 1'b0;
        pulse(8'b0100_0000);
        pulse(8'b0000_0100);
        pulse(8'b0001_0010);
        take("R5 first arrival", 6);
        pulse(8'b0000_0001);
        check_irq("R4 held while in service", 1'b0);
        end_handler();
        take("R5 second arrival", 2);
        end_handler();
        take("R5 same cycle low index", 1);
        end_handler();
        take("R5 same cycle high index", 4);
        end_handler();
        take("R4 pending kept", 0);
        end_handler();
        check_irq("R5 queue drained", 1'b0);
    endtask

    task automatic t_seq_dup();
        nest = 1'b0;
        pulse(8'b0000_1000);
        pulse(8'b0000_1000);
        pulse(8'b0010_0000);
        take("R9 merged first", 3);
        end_handler();
        take("R9 next source", 5);
        end_handler();
        check_irq("R9 served once", 1'b0);
    endtask

    task automatic t_nested();
        nest = 1'b1;
        tick();
        pulse(8'b0010_0000);
        take("R6 base handler", 5);
        pulse(8'b0100_0000);
        check_irq("R6 lower not presented", 1'b0);
        pulse(8'b0000_0100);
        take("R6 preempt by 2", 2);
        pulse(8'b0000_0010);
        take("R7 preempt by 1", 1);
        check_irq("R6 nothing outranks 1", 1'b0);
        end_handler();
        check_irq("R7 still under 2", 1'b0);
        end_handler();
        check_irq("R7 still under 5", 1'b0);
        end_handler();
        take("R7 lower after all end", 6);
        end_handler();
        check_irq("R7 idle", 1'b0);
        pulse(8'b0001_1000);
        take("R6 highest of two", 3);
        check_irq("R6 4 below 3", 1'b0);
        end_handler();
        take("R6 remaining", 4);
        end_handler();
        check_irq("R6 idle", 1'b0);
        nest = 1'b0;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_edge_level();
        t_ack_ignored();
        t_seq_order();
        t_seq_dup();
        t_nested();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule